// File: doc/BRIEF.md
# Non-volatile word lookup register

This block exposes one 32-bit register that software uses to fetch 16-bit words from a small non-volatile word store. Software writes the register with a word address and the launch bit set. The block clears the launch bit at once. Two cycles later it raises the completion bit and places the fetched word in the upper half of the same register. A write with the launch bit clear is kept exactly as written, so software can clear the completion flag or preset any field.

The word store is modelled as an array of registers that comes out of reset holding a fixed image. A separate loader port can overwrite single words, for example to install a different image before software runs. Addresses beyond the end of the store do not index the array. They complete normally and return an all-ones word.

Top module: `nvw_lookup_reg`

## Requirements
- R1: After reset the register reads 0. With the default depth of 64, store word i holds i*0x0101 for i = 0..62, and word 63 holds the value that brings the 16-bit sum of all 64 words to 0xBABA.
- R2: A register write with bit 0 clear stores the written 32-bit value unchanged. It reads back from the next cycle on and holds while no further write occurs.
- R3: A register write with bit 0 set gives, from the next cycle on, a register value with bit 0 = 0, bit 1 (done) = 0, bits 15:2 equal to the written 14-bit address, and bits 31:16 = 0.
- R4: A launched lookup that is not interrupted sets bit 1 exactly two cycles after the write. Bits 31:16 then hold the addressed store word, and bits 15:2 still hold the address. A read in the cycle between shows bit 1 = 0.
- R5: A lookup whose address is 64 or more (store depth or above) completes with the same timing and returns 0xFFFF in bits 31:16.
- R6: The 16-bit sum of the 64 words returned by lookups of addresses 0..63 after reset equals 0xBABA.
- R7: A loader write (ld_en high for one cycle) replaces the word at ld_addr. Later lookups of that address return the loaded value, and other words are unchanged.
- R8: A register write that arrives while a lookup is pending cancels it. With bit 0 clear, the written value stays and done is never set by the old lookup. With bit 0 set, the new address is fetched and completes two cycles after the new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Current register value |
| ld_en | input | 1 | Loader write strobe for the word store |
| ld_addr | input | 6 | Loader word index |
| ld_data | input | 16 | Loader word value |

## Verification
The case that is hardest to reach from the ports is a write landing inside the two-cycle lookup window. Software normally polls and waits, so it never does this. The bench drives a plain write, and in a second test a fresh launch, on the cycle right after a launch. It then watches that the old fetch never reaches the register. Exhaustive sweeps over every store address, before and after a full reload through the loader port, cover the contents. A few far out-of-range addresses cover the miss path.

// File: rtl/nvw_pkg.sv
package nvw_pkg;

    localparam int ADDR_W = 14;
    localparam int WORD_W = 16;
    localparam int REG_W  = 32;
    localparam logic [WORD_W-1:0] MISS_WORD = 16'hFFFF;

    // Register layout; software decodes these positions.
    typedef struct packed {
        logic [WORD_W-1:0] word;   // 31:16
        logic [ADDR_W-1:0] addr;   // 15:2
        logic              done;   // 1
        logic              go;     // 0
    } lookup_reg_t;

    typedef enum logic [1:0] {
        LK_IDLE   = 2'd0,
        LK_FETCH  = 2'd1,
        LK_COMMIT = 2'd2
    } lookup_state_t;

    // Reset image: ramp words, last word balances the sum to target.
    function automatic logic [WORD_W-1:0] image_word(input int idx, input int depth,
                                                     input logic [WORD_W-1:0] target);
        logic [WORD_W-1:0] acc;
        acc = '0;
        if (idx < depth - 1) begin
            return WORD_W'(idx * 257);
        end
        for (int j = 0; j < depth - 1; j++) begin
            acc = acc + WORD_W'(j * 257);
        end
        return target - acc;
    endfunction

endpackage

// File: rtl/nvw_word_store.sv
module nvw_word_store
    import nvw_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter logic [WORD_W-1:0] IMAGE_SUM = 16'hBABA,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [WORD_W-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q <= image_word(g, DEPTH, IMAGE_SUM);
            end else if (ld_en && (ld_addr == IDX_W'(g))) begin
                cell_q <= ld_data;
            end
        end
        assign cells[g] = cell_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_word <= '0;
        end else if (rd_en) begin
            rd_word <= cells[rd_idx];
        end
    end

endmodule

// File: rtl/nvw_lookup_seq.sv
module nvw_lookup_seq
    import nvw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic reg_wr,
    input  logic launch,
    output logic fetch,
    output logic commit
);

    lookup_state_t state_q, state_d;

    always_comb begin
        state_d = LK_IDLE;
        if (launch) begin
            state_d = LK_FETCH;
        end else if (!reg_wr) begin
            unique case (state_q)
                LK_FETCH:  state_d = LK_COMMIT;
                default:   state_d = LK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign fetch  = (state_q == LK_FETCH);
    assign commit = (state_q == LK_COMMIT);

    // R8
    cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !launch) |=> (!fetch && !commit));

endmodule

// File: rtl/nvw_lookup_reg.sv
module nvw_lookup_reg
    import nvw_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter logic [WORD_W-1:0] IMAGE_SUM = 16'hBABA,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_addr,
    input  logic [WORD_W-1:0] ld_data
);

    localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(DEPTH);

    lookup_reg_t reg_q;
    lookup_reg_t wr_v;
    logic        launch, fetch, commit, in_range;
    logic [WORD_W-1:0] store_word;

    assign wr_v     = lookup_reg_t'(reg_wdata);
    assign launch   = reg_wr && wr_v.go;
    assign in_range = (reg_q.addr < DEPTH_A);

    nvw_lookup_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .reg_wr (reg_wr),
        .launch (launch),
        .fetch  (fetch),
        .commit (commit)
    );

    nvw_word_store #(
        .DEPTH     (DEPTH),
        .IMAGE_SUM (IMAGE_SUM)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .rd_en   (fetch && in_range),
        .rd_idx  (reg_q.addr[IDX_W-1:0]),
        .rd_word (store_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
        end else if (reg_wr) begin
            if (wr_v.go) begin
                reg_q.word <= '0;
                reg_q.addr <= wr_v.addr;
                reg_q.done <= 1'b0;
                reg_q.go   <= 1'b0;
            end else begin
                reg_q <= wr_v;
            end
        end else if (commit) begin
            reg_q.done <= 1'b1;
            reg_q.word <= in_range ? store_word : MISS_WORD;
        end
    end

    assign reg_rdata = reg_q;

    // R2
    plain_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_wdata[0]) |=> (reg_rdata == $past(reg_wdata)));

    // R3
    launch_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata[0]) |=> (reg_rdata[1:0] == 2'b00 && reg_rdata[31:16] == '0));

    // R4
    commit_done_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && !reg_wr) |=> (reg_rdata[1] && $stable(reg_rdata[15:2])));

    // R5
    miss_word_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && !reg_wr && !in_range) |=> (reg_rdata[31:16] == MISS_WORD));

endmodule

// File: tb/tb_nvw_lookup_reg.sv
`timescale 1ns/1ps
module tb_nvw_lookup_reg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ld_en = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    nvw_lookup_reg dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] reset_word(input int i);
        logic [15:0] s;
        s = '0;
        if (i < 63) return 16'(i * 257);
        for (int j = 0; j < 63; j++) s = s + 16'(j * 257);
        return 16'hBABA - s;
    endfunction

    function automatic logic [31:0] launch_val(input int a);
        return {16'h0, 14'(a), 1'b0, 1'b1};
    endfunction

    // Full lookup with window checks; returns the fetched word.
    task automatic lookup(input int a, input logic [15:0] exp_word, input string req,
                          output logic [15:0] got);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = launch_val(a);
        @(negedge clk); reg_wr = 1'b0;
        chk("R3", reg_rdata, {16'h0, 14'(a), 2'b00});
        @(negedge clk);
        chk("R4 window", {31'h0, reg_rdata[1]}, 32'h0);
        @(negedge clk);
        chk(req, reg_rdata, {exp_word, 14'(a), 2'b10});
        got = reg_rdata[31:16];
    endtask

    task automatic load(input int a, input logic [15:0] d);
        @(negedge clk); ld_en = 1'b1; ld_addr = 6'(a); ld_data = d;
        @(negedge clk); ld_en = 1'b0;
    endtask

    task automatic plain(input logic [31:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
        chk("R2", reg_rdata, v);
        @(negedge clk);
        @(negedge clk);
        chk("R2 hold", reg_rdata, v);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog act=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] got;
        logic [15:0] sum;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1", reg_rdata, 32'h0);

        // R1 / R4 / R6: sweep of the reset image
        sum = '0;
        for (int a = 0; a < 64; a++) begin
            lookup(a, reset_word(a), "R1 R4 image", got);
            sum = sum + got;
        end
        chk("R6", {16'h0, sum}, 32'h0000_BABA);

        // R5: out-of-range addresses
        lookup(64, 16'hFFFF, "R5", got);
        lookup(1000, 16'hFFFF, "R5", got);
        lookup(16383, 16'hFFFF, "R5", got);

        // R2: plain writes, including a preset done bit
        plain(32'hDEAD_BEEE);
        plain(32'h0000_0002);
        plain(32'hFFFF_FFFE);
        plain(32'h1234_5678);

        // R7: reload every word, then sweep
        for (int a = 0; a < 64; a++) load(a, 16'(a * 37) ^ 16'h5A5A);
        for (int a = 0; a < 64; a++) lookup(a, 16'(a * 37) ^ 16'h5A5A, "R7", got);
        load(10, 16'hC0DE);
        lookup(10, 16'hC0DE, "R7 single", got);
        lookup(11, 16'(11 * 37) ^ 16'h5A5A, "R7 neighbour", got);

        // R8: plain write one cycle after a launch cancels it
        @(negedge clk); reg_wr = 1'b1; reg_wdata = launch_val(5);
        @(negedge clk); reg_wdata = 32'hABCD_0010;
        @(negedge clk); reg_wr = 1'b0;
        chk("R8 cancel", reg_rdata, 32'hABCD_0010);
        @(negedge clk);
        chk("R8 cancel", reg_rdata, 32'hABCD_0010);
        @(negedge clk);
        chk("R8 cancel", reg_rdata, 32'hABCD_0010);

        // R8: relaunch one cycle after a launch
        @(negedge clk); reg_wr = 1'b1; reg_wdata = launch_val(5);
        @(negedge clk); reg_wdata = launch_val(6);
        @(negedge clk); reg_wr = 1'b0;
        chk("R8 relaunch", reg_rdata, {16'h0, 14'd6, 2'b00});
        @(negedge clk);
        chk("R8 relaunch", reg_rdata, {16'h0, 14'd6, 2'b00});
        @(negedge clk);
        chk("R8 relaunch", reg_rdata, {16'(6 * 37) ^ 16'h5A5A, 14'd6, 2'b10});

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule